// File: doc/BRIEF.md
# Receive Destination Address Filter

This block sits on the receive path of an Ethernet MAC and decides, frame by frame, whether a frame is kept and which of eight receive channels it is steered to. It watches the first six bytes of each frame, which carry the 48-bit destination address, on a byte stream whose first byte is flagged by a start-of-frame strobe. Once the sixth byte has been taken, it publishes an accept flag and a 3-bit channel number. These stay on the outputs until the next frame starts.

Four acceptance classes are checked, in a fixed order of precedence. Promiscuous mode takes every frame. Broadcast takes the all-ones address. A unicast match compares against a programmed station address whose last byte may differ per channel. A multicast frame is taken when a 64-entry hash table holds a set bit at the index the frame's address folds to. The fold is a six-bit XOR of shifted address bytes, not a CRC. A small write-only register port holds the control word, the station address, the unicast channel enables and the hash table.

Top module: `rxaf_top`

## Requirements
- R1: After reset, res_valid, res_accept and res_chan are 0. All programmed state is zero, so every frame is rejected.
- R2: A byte with in_valid and in_sof is address byte 0. Each later byte with in_valid fills the next position. Cycles with in_valid low pause the capture. Bytes after the sixth are ignored. A new in_sof restarts the capture at byte 0, even partway through an address.
- R3: res_valid rises on the clock edge after the edge that takes address byte 5. The verdict then holds until the edge that takes the next in_sof byte, which clears res_valid, res_accept and res_chan to 0.
- R4: When control bit 21 is set, every frame is accepted on the channel in control bits 18:16, whatever its address.
- R5: An all-ones destination is accepted on the channel in control bits 10:8 when control bit 13 is set. It is not taken by the broadcast class when that bit is clear.
- R6: Unicast match: bytes 0 to 3 equal register 1 (byte 0 in bits 7:0, up to byte 3 in bits 31:24), byte 4 equals register 2 bits 7:0, and byte 5 equals bits 7:0 of register 8+c for a channel c whose enable bit is set. The frame is then accepted on the lowest such channel c.
- R7: A write to register 3 sets the unicast enable bits where the data bits 7:0 are one. A write to register 4 clears them where the data bits are one. Zero data bits leave the enables unchanged.
- R8: A frame is multicast when byte 0 bit 0 is set and the address is not all ones. Its hash index is the low 6 bits of the XOR of per-byte terms: (b>>2)^(b<<4) for bytes 0 and 3, (b>>4)^(b<<2) for bytes 1 and 4, and (b>>6)^b for bytes 2 and 5. Index bit 5 selects register 6 (set) or register 5 (clear), and bits 4:0 select the bit. If control bit 5 is set and that bit is one, the frame is accepted on the channel in control bits 2:0.
- R9: With registers 5 and 6 both all ones and control bit 5 set, every multicast frame is accepted.
- R10: Precedence is promiscuous, then broadcast, then unicast match, then multicast hit. A frame that no enabled class takes gives res_accept 0 and res_chan 0.
- R11: Register 0 is the control word. Writes to register 7 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register number |
| wr_data | input | 32 | Register write data |
| in_valid | input | 1 | Receive byte valid |
| in_sof | input | 1 | Marks the first byte of a frame |
| in_byte | input | 8 | Receive byte |
| res_valid | output | 1 | Verdict valid for the current frame |
| res_accept | output | 1 | Frame accepted |
| res_chan | output | 3 | Destination channel |

## Verification
The bench goes after precedence collisions. An all-ones address that also matches a programmed station address must go to the broadcast channel. A station address with the group bit set must take the unicast channel rather than the multicast one. A design with the order swapped would steer these frames to the wrong channel. Hash indices on both sides of 32 are exercised, so a swapped word select or a misread fold term would turn hits into misses. Restarts partway through an address, pauses inside an address and trailing payload bytes are also sent, because a capture counter that mishandles them would compare the wrong bytes or overwrite a verdict that should be holding.

// File: rtl/rxaf_pkg.sv
// Shared constants, types and the multicast hash fold for the receive
// address filter. Assumes a 6-byte destination address, byte 0 first.
package rxaf_pkg;
    localparam int ADDR_BYTES = 6;
    localparam int HASH_W     = 6;
    localparam int HASH_SIZE  = 1 << HASH_W;
    localparam int CH_W       = 3;

    // Control word field positions
    localparam int CTL_PROM_EN = 21;
    localparam int CTL_PROM_CH = 16;
    localparam int CTL_BC_EN   = 13;
    localparam int CTL_BC_CH   = 8;
    localparam int CTL_MC_EN   = 5;
    localparam int CTL_MC_CH   = 0;

    // Register numbers
    localparam int RA_CTRL     = 0;
    localparam int RA_STN_HI   = 1;
    localparam int RA_STN_MID  = 2;
    localparam int RA_UC_SET   = 3;
    localparam int RA_UC_CLR   = 4;
    localparam int RA_HASH_LO  = 5;
    localparam int RA_HASH_HI  = 6;
    localparam int RA_LOW_BASE = 8;

    typedef logic [ADDR_BYTES-1:0][7:0] mac_t;

    typedef struct packed {
        logic            accept;
        logic [CH_W-1:0] chan;
    } verdict_t;

    // Fold the six address bytes into a hash table index.
    function automatic logic [HASH_W-1:0] hash_fold(input mac_t a);
        logic [7:0] acc;
        logic [7:0] b;
        acc = '0;
        for (int i = 0; i < ADDR_BYTES; i++) begin
            b = a[i];
            case (i % 3)
                0:       acc = acc ^ (b >> 2) ^ (b << 4);
                1:       acc = acc ^ (b >> 4) ^ (b << 2);
                default: acc = acc ^ (b >> 6) ^ b;
            endcase
        end
        return acc[HASH_W-1:0];
    endfunction
endpackage

// File: rtl/rxaf_regs.sv
// Write-only configuration store for the address filter: control word,
// station address, per-channel last byte, unicast enables and hash table.
// Assumes NUM_CH <= 8 so that the per-channel registers fit in the map.
module rxaf_regs
    import rxaf_pkg::*;
#(
    parameter int NUM_CH = 8,
    parameter int REG_AW = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic [REG_AW-1:0]      wr_addr,
    input  logic [31:0]            wr_data,
    output logic [31:0]            ctrl,
    output logic [31:0]            stn_hi,
    output logic [7:0]             stn_mid,
    output logic [NUM_CH-1:0][7:0] ch_low,
    output logic [NUM_CH-1:0]      uc_en,
    output logic [HASH_SIZE-1:0]   hash_tbl
);
    localparam int HALF = HASH_SIZE / 2;

    function automatic logic hit(input logic [REG_AW-1:0] a, input int n);
        return wr_en && (a == REG_AW'(n));
    endfunction

    // Control word and the shared station address bytes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl    <= '0;
            stn_hi  <= '0;
            stn_mid <= '0;
        end else begin
            if (hit(wr_addr, RA_CTRL))    ctrl    <= wr_data;
            if (hit(wr_addr, RA_STN_HI))  stn_hi  <= wr_data;
            if (hit(wr_addr, RA_STN_MID)) stn_mid <= wr_data[7:0];
        end
    end

    // Unicast channel enables: one write port sets, another clears.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            uc_en <= '0;
        end else if (hit(wr_addr, RA_UC_SET)) begin
            uc_en <= uc_en | wr_data[NUM_CH-1:0];
        end else if (hit(wr_addr, RA_UC_CLR)) begin
            uc_en <= uc_en & ~wr_data[NUM_CH-1:0];
        end
    end

    // Multicast hash table, two words.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hash_tbl <= '0;
        end else begin
            if (hit(wr_addr, RA_HASH_LO)) hash_tbl[HALF-1:0]         <= wr_data[HALF-1:0];
            if (hit(wr_addr, RA_HASH_HI)) hash_tbl[HASH_SIZE-1:HALF] <= wr_data[HALF-1:0];
        end
    end

    // Per-channel last address byte.
    for (genvar c = 0; c < NUM_CH; c++) begin : g_low
        always_ff @(posedge clk) begin
            if (!rst_n)                            ch_low[c] <= '0;
            else if (hit(wr_addr, RA_LOW_BASE + c)) ch_low[c] <= wr_data[7:0];
        end
    end

    a_r7_set_takes: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == REG_AW'(RA_UC_SET)) |=> ((~uc_en & $past(wr_data[NUM_CH-1:0])) == '0));
    a_r7_clear_takes: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == REG_AW'(RA_UC_CLR)) |=> ((uc_en & $past(wr_data[NUM_CH-1:0])) == '0));
endmodule

// File: rtl/rxaf_capture.sv
// Collects the six destination address bytes from the receive byte
// stream and pulses done for one cycle after the sixth byte is taken.
// Assumes in_sof is only meaningful together with in_valid.
module rxaf_capture
    import rxaf_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       in_valid,
    input  logic       in_sof,
    input  logic [7:0] in_byte,
    output mac_t       addr,
    output logic       done,
    output logic       sof_take
);
    localparam int IDX_W = $clog2(ADDR_BYTES + 1);
    localparam logic [IDX_W-1:0] IDX_FULL = IDX_W'(ADDR_BYTES);
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(ADDR_BYTES - 1);

    logic [IDX_W-1:0] idx;

    assign sof_take = in_valid && in_sof;

    // Byte position counter and address store; idle once six bytes are in.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx  <= IDX_FULL;
            addr <= '0;
            done <= 1'b0;
        end else begin
            done <= 1'b0;
            if (sof_take) begin
                addr[0] <= in_byte;
                idx     <= IDX_W'(1);
            end else if (in_valid && idx < IDX_FULL) begin
                addr[idx] <= in_byte;
                idx       <= idx + IDX_W'(1);
                done      <= (idx == IDX_LAST);
            end
        end
    end

    a_r3_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    a_r2_done_from_byte: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> ($past(in_valid) && !$past(in_sof)));
endmodule

// File: rtl/rxaf_match.sv
// Classifies the captured address (promiscuous, broadcast, unicast,
// multicast hash) and registers the verdict when capture completes.
// Assumes addr is stable from done until the next sof.
module rxaf_match
    import rxaf_pkg::*;
#(
    parameter int NUM_CH = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  mac_t                   addr,
    input  logic                   done,
    input  logic                   sof_take,
    input  logic [31:0]            ctrl,
    input  logic [31:0]            stn_hi,
    input  logic [7:0]             stn_mid,
    input  logic [NUM_CH-1:0][7:0] ch_low,
    input  logic [NUM_CH-1:0]      uc_en,
    input  logic [HASH_SIZE-1:0]   hash_tbl,
    output logic                   res_valid,
    output logic                   res_accept,
    output logic [CH_W-1:0]        res_chan
);
    logic              is_bcast, is_mcast, upper_eq, uc_hit, mc_hit;
    logic [NUM_CH-1:0] ch_hit;
    logic [CH_W-1:0]   uc_chan;
    verdict_t          vd;

    // Per-channel last byte comparison.
    for (genvar c = 0; c < NUM_CH; c++) begin : g_hit
        assign ch_hit[c] = uc_en[c] && (addr[ADDR_BYTES-1] == ch_low[c]);
    end

    // Address classes and the lowest matching unicast channel.
    always_comb begin
        is_bcast = &addr;
        is_mcast = addr[0][0] && !is_bcast;
        upper_eq = (addr[3:0] == stn_hi) && (addr[4] == stn_mid);
        uc_hit   = upper_eq && (|ch_hit);
        mc_hit   = is_mcast && hash_tbl[hash_fold(addr)];
        uc_chan  = '0;
        for (int c = NUM_CH - 1; c >= 0; c--) begin
            if (ch_hit[c]) uc_chan = CH_W'(c);
        end
    end

    // Verdict by class precedence.
    always_comb begin
        vd = '0;
        if (ctrl[CTL_PROM_EN])
            vd = '{accept: 1'b1, chan: ctrl[CTL_PROM_CH +: CH_W]};
        else if (is_bcast && ctrl[CTL_BC_EN])
            vd = '{accept: 1'b1, chan: ctrl[CTL_BC_CH +: CH_W]};
        else if (uc_hit)
            vd = '{accept: 1'b1, chan: uc_chan};
        else if (mc_hit && ctrl[CTL_MC_EN])
            vd = '{accept: 1'b1, chan: ctrl[CTL_MC_CH +: CH_W]};
    end

    // Publish on completion, withdraw on the next frame start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid  <= 1'b0;
            res_accept <= 1'b0;
            res_chan   <= '0;
        end else if (done) begin
            res_valid  <= 1'b1;
            res_accept <= vd.accept;
            res_chan   <= vd.chan;
        end else if (sof_take) begin
            res_valid  <= 1'b0;
            res_accept <= 1'b0;
            res_chan   <= '0;
        end
    end

    a_r3_rise_after_done: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(res_valid) |-> $past(done));
    a_r3_clear_on_sof: assert property (@(posedge clk) disable iff (!rst_n)
        (sof_take && !done) |=> !res_valid);
    a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!done && !sof_take) |=> ($stable(res_valid) && $stable(res_accept) && $stable(res_chan)));
    a_r4_promisc: assert property (@(posedge clk) disable iff (!rst_n)
        (done && ctrl[CTL_PROM_EN]) |=> (res_accept && res_chan == $past(ctrl[CTL_PROM_CH +: CH_W])));
    a_r10_reject_chan0: assert property (@(posedge clk) disable iff (!rst_n)
        (!res_accept) |-> (res_chan == '0));
    a_r10_accept_valid: assert property (@(posedge clk) disable iff (!rst_n)
        res_accept |-> res_valid);
endmodule

// File: rtl/rxaf_top.sv
// Receive destination address filter: captures the destination address
// from the byte stream and reports accept and channel per frame.
// Assumes NUM_CH <= 8 and REG_AW = 4 for the register numbering.
module rxaf_top
    import rxaf_pkg::*;
#(
    parameter int NUM_CH = 8,
    parameter int REG_AW = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [REG_AW-1:0] wr_addr,
    input  logic [31:0]       wr_data,
    input  logic              in_valid,
    input  logic              in_sof,
    input  logic [7:0]        in_byte,
    output logic              res_valid,
    output logic              res_accept,
    output logic [CH_W-1:0]   res_chan
);
    logic [31:0]            ctrl, stn_hi;
    logic [7:0]             stn_mid;
    logic [NUM_CH-1:0][7:0] ch_low;
    logic [NUM_CH-1:0]      uc_en;
    logic [HASH_SIZE-1:0]   hash_tbl;
    mac_t                   addr;
    logic                   done, sof_take;

    rxaf_regs #(.NUM_CH(NUM_CH), .REG_AW(REG_AW)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .ctrl(ctrl), .stn_hi(stn_hi), .stn_mid(stn_mid),
        .ch_low(ch_low), .uc_en(uc_en), .hash_tbl(hash_tbl)
    );

    rxaf_capture u_cap (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sof(in_sof),
        .in_byte(in_byte), .addr(addr), .done(done), .sof_take(sof_take)
    );

    rxaf_match #(.NUM_CH(NUM_CH)) u_match (
        .clk(clk), .rst_n(rst_n), .addr(addr), .done(done), .sof_take(sof_take),
        .ctrl(ctrl), .stn_hi(stn_hi), .stn_mid(stn_mid), .ch_low(ch_low),
        .uc_en(uc_en), .hash_tbl(hash_tbl), .res_valid(res_valid),
        .res_accept(res_accept), .res_chan(res_chan)
    );
endmodule

// File: tb/rxaf_top_bench.sv
module rxaf_top_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic        in_valid = 1'b0;
    logic        in_sof = 1'b0;
    logic [7:0]  in_byte = '0;
    logic        res_valid, res_accept;
    logic [2:0]  res_chan;

    int checks = 0;
    int failures = 0;

    typedef struct {
        logic       acc;
        logic [2:0] ch;
        string      tag;
    } exp_t;
    exp_t q[$];
    exp_t mon_e;
    logic prev_v = 1'b0;

    // Shadow of the programmed state, kept from the register rules.
    logic [31:0] sh_ctrl = '0, sh_hi = '0;
    logic [7:0]  sh_mid = '0, sh_en = '0;
    logic [7:0]  sh_low [8];
    logic [63:0] sh_hash = '0;

    rxaf_top u_rxaf_top (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .in_valid(in_valid), .in_sof(in_sof),
        .in_byte(in_byte), .res_valid(res_valid), .res_accept(res_accept),
        .res_chan(res_chan)
    );

    always #2.5 clk = ~clk;

    function automatic logic [7:0] byte_of(input logic [47:0] a, input int i);
        return a[47-8*i -: 8];
    endfunction

    function automatic logic [5:0] bhash(input logic [47:0] a);
        logic [7:0] s = 8'h00;
        for (int i = 0; i < 6; i++) begin
            logic [7:0] b = byte_of(a, i);
            if (i == 0 || i == 3)      s = s ^ (b >> 2) ^ (b << 4);
            else if (i == 1 || i == 4) s = s ^ (b >> 4) ^ (b << 2);
            else                       s = s ^ (b >> 6) ^ b;
        end
        return s[5:0];
    endfunction

    function automatic exp_t model(input logic [47:0] a);
        exp_t e;
        logic bc = (a == 48'hFFFF_FFFF_FFFF);
        logic mc = a[40] && !bc;
        logic up = 1'b1;
        int uc = -1;
        for (int i = 0; i < 4; i++) if (byte_of(a, i) != sh_hi[8*i +: 8]) up = 1'b0;
        if (byte_of(a, 4) != sh_mid) up = 1'b0;
        for (int c = 7; c >= 0; c--) if (up && sh_en[c] && sh_low[c] == byte_of(a, 5)) uc = c;
        e.acc = 1'b0; e.ch = 3'd0; e.tag = "";
        if (sh_ctrl[21])                begin e.acc = 1'b1; e.ch = sh_ctrl[18:16]; end
        else if (bc && sh_ctrl[13])     begin e.acc = 1'b1; e.ch = sh_ctrl[10:8]; end
        else if (uc >= 0)               begin e.acc = 1'b1; e.ch = 3'(uc); end
        else if (mc && sh_ctrl[5] && sh_hash[bhash(a)]) begin e.acc = 1'b1; e.ch = sh_ctrl[2:0]; end
        return e;
    endfunction

    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 4'(a); wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        case (a)
            0: sh_ctrl = d;
            1: sh_hi = d;
            2: sh_mid = d[7:0];
            3: sh_en = sh_en | d[7:0];
            4: sh_en = sh_en & ~d[7:0];
            5: sh_hash[31:0] = d;
            6: sh_hash[63:32] = d;
            default: if (a >= 8) sh_low[a-8] = d[7:0];
        endcase
    endtask

    task automatic fail(input string req, input string what, input int act, input int exp);
        failures++;
        $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    endtask

    // Driver: push the expected verdict, then drive the address and payload.
    task automatic send(input logic [47:0] a, input string tag, input bit gap, input int prefix);
        exp_t x = model(a);
        x.tag = tag;
        for (int p = 0; p < prefix; p++) begin
            @(negedge clk);
            in_valid = 1'b1; in_sof = (p == 0); in_byte = 8'hA5;
        end
        q.push_back(x);
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            if (i == 1) begin
                checks++;
                if (res_valid !== 1'b0) fail("R3", {tag, " valid after sof"}, res_valid, 0);
            end
            if (gap && i == 3) begin
                in_valid = 1'b0; in_sof = 1'b0;
                @(negedge clk);
            end
            in_valid = 1'b1; in_sof = (i == 0); in_byte = byte_of(a, i);
        end
        for (int t = 0; t < 3; t++) begin
            @(negedge clk);
            in_valid = 1'b1; in_sof = 1'b0; in_byte = 8'h5A ^ 8'(t);
        end
        @(negedge clk);
        in_valid = 1'b0;
        repeat (2) @(negedge clk);
        checks++;
        if (res_valid !== 1'b1 || res_accept !== x.acc || res_chan !== x.ch)
            fail("R3", {tag, " verdict not held"}, {res_valid, res_accept, res_chan}, {1'b1, x.acc, x.ch});
    endtask

    // Monitor: compare each new verdict against the scoreboard head.
    always @(negedge clk) begin
        if (!rst_n) begin
            prev_v = 1'b0;
        end else begin
            if (res_valid && !prev_v) begin
                checks++;
                if (q.size() == 0) begin
                    fail("R3", "unexpected verdict", 1, 0);
                end else begin
                    mon_e = q.pop_front();
                    if (res_accept !== mon_e.acc || res_chan !== mon_e.ch)
                        fail(mon_e.tag, "accept/chan", {res_accept, res_chan}, {mon_e.acc, mon_e.ch});
                end
            end
            prev_v = res_valid;
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        fail("R3", "watchdog", 0, 1);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [47:0] ma, mb, mh;
        for (int c = 0; c < 8; c++) sh_low[c] = 8'h00;
        repeat (3) @(negedge clk);
        checks++;
        if (res_valid !== 1'b0 || res_accept !== 1'b0 || res_chan !== 3'd0)
            fail("R1", "outputs in reset", {res_valid, res_accept, res_chan}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        checks++;
        if (res_valid !== 1'b0) fail("R1", "valid after reset", res_valid, 0);

        // R1: nothing programmed, everything rejected
        send(48'h0000_0000_0000, "R1 zero addr", 0, 0);
        send(48'hFFFF_FFFF_FFFF, "R1 bcast unprogrammed", 0, 0);

        // R5: broadcast on channel 5
        wr(0, 32'h0000_2500);
        send(48'hFFFF_FFFF_FFFF, "R5 bcast", 0, 0);

        // R6: station 00:11:22:33:44:55 on channel 3, then also channel 1
        wr(1, 32'h3322_1100);
        wr(2, 32'h0000_0044);
        wr(8 + 3, 32'h55);
        wr(3, 32'h08);
        send(48'h0011_2233_4455, "R6 unicast ch3", 0, 0);
        send(48'h0011_2233_4456, "R6 last byte miss", 0, 0);
        send(48'h0011_2233_5455, "R6 mid byte miss", 0, 0);
        wr(8 + 1, 32'h55);
        wr(3, 32'h02);
        send(48'h0011_2233_4455, "R6 lowest channel", 0, 0);
        send(48'h0011_2233_4455, "R2 paused capture", 1, 0);
        send(48'h0011_2233_4455, "R2 restart on sof", 0, 3);

        // R7: clear channel 1, zero bits leave the rest
        wr(4, 32'h02);
        send(48'h0011_2233_4455, "R7 after clear", 0, 0);
        wr(4, 32'h00);
        wr(3, 32'h00);
        send(48'h0011_2233_4455, "R7 zero writes", 0, 0);

        // R8: multicast hash hits in both words
        wr(0, 32'h0000_2526);
        ma = 48'h0100_5E00_0001;
        if (bhash(ma) < 32) wr(5, 32'h1 << bhash(ma));
        else                wr(6, 32'h1 << (bhash(ma) - 32));
        send(ma, "R8 mcast hit", 0, 0);
        mb = 48'h3333_0000_0001;
        send(mb, "R8 mcast other index", 0, 0);
        mh = 48'h0100_0000_0000;
        for (int k = 0; k < 256; k++) begin
            if (bhash(48'h0100_0000_0000 | 48'(k)) >= 32) begin
                mh = 48'h0100_0000_0000 | 48'(k);
                break;
            end
        end
        wr(6, 32'h1 << (bhash(mh) - 32));
        send(mh, "R8 mcast high word", 0, 0);
        wr(0, 32'h0000_2506);
        send(mh, "R8 mcast disabled", 0, 0);

        // R9: all-ones table accepts any multicast
        wr(0, 32'h0000_2526);
        wr(5, 32'hFFFF_FFFF);
        wr(6, 32'hFFFF_FFFF);
        send(48'h0F12_3456_789A, "R9 any mcast", 0, 0);
        send(48'h0E12_3456_789A, "R9 not mcast", 0, 0);

        // R10: precedence collisions
        wr(1, 32'hFFFF_FFFF);
        wr(2, 32'hFF);
        wr(8 + 2, 32'hFF);
        wr(3, 32'h04);
        send(48'hFFFF_FFFF_FFFF, "R10 bcast over unicast", 0, 0);
        wr(0, 32'h0000_0026);
        send(48'hFFFF_FFFF_FFFF, "R10 unicast when bcast off", 0, 0);
        wr(1, 32'h0000_0003);
        wr(2, 32'h00);
        wr(8 + 4, 32'h07);
        wr(3, 32'h10);
        send(48'h0300_0000_0007, "R10 unicast over mcast", 0, 0);

        // R11: unused register write has no effect
        wr(0, 32'h0);
        wr(7, 32'hFFFF_FFFF);
        send(48'h0212_3456_789A, "R11 unused write", 0, 0);

        // R4: promiscuous on channel 7 overrides everything
        wr(0, 32'h0027_2526);
        send(48'h0212_3456_789A, "R4 promisc unicast", 0, 0);
        send(48'hFFFF_FFFF_FFFF, "R4 promisc bcast", 0, 0);

        repeat (4) @(negedge clk);
        checks++;
        if (q.size() != 0) fail("R3", "verdicts missing", q.size(), 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule